// File: doc/BRIEF.md
# Host Compressed-Data FIFO with Service Interrupts

This block buffers compressed words between a host data port and an internal coder. One control input chooses the direction. In encode mode the coder fills the buffer and the host drains it. In decode mode the host fills the buffer and the coder drains it. The request lines of the side that is not active in a given direction are ignored. The buffer is 512 words deep and 32 bits wide by default.

A 4-bit service level, scaled by 32, gives a threshold in entries. In encode mode the service request asks the host to drain the buffer once the fill has climbed to that threshold. In decode mode it asks the host to refill the buffer once the fill has dropped to that threshold. The live request drives its own pin and also sets a status bit.

Seven sticky status bits collect events: four come from outside the block and three are generated by the FIFO. A host-written mask picks which of those bits reach the single interrupt line. The host clears a status bit by writing 1 to it.

Top module: `hfifo_host`

## Requirements
- R1: Words leave the buffer in the order they entered it. `fill` counts the stored words from 0 to 512. `empty` is 1 when the fill is 0 and `full` is 1 when the fill is 512. `host_rdata` and `core_rdata` both show the oldest stored word.
- R2: When `dec_mode`=0, only `core_push` writes and only `host_pop` reads. When `dec_mode`=1, only `host_push` writes and only `core_pop` reads. A push or pop from the inactive side leaves `fill` unchanged.
- R3: A push while full stores nothing and leaves the fill at 512. A pop while empty removes nothing. Either event sets status bit 4 (FIFO error) at the same clock edge.
- R4: When `dec_mode`=0, `svc_req` is 1 exactly when `fill` >= `svc_level`*32. A level of 0 therefore always requests service.
- R5: When `dec_mode`=1, `svc_req` is 1 exactly when `fill` <= `svc_level`*32.
- R6: Status bit 2 (FIFO stop) is set one edge after the buffer is full in encode mode, or one edge after it is empty in decode mode.
- R7: Status bits are sticky. A bit stays at 1 after its cause goes away. On a clock edge with `stat_clr_we`=1, each bit set to 1 in `stat_clr_data` is cleared, and bits written as 0 are left alone. If a cause is present at the same edge as a clear, the cause wins.
- R8: `irq` equals the OR of (`status` AND `mask`). `mask` is loaded from `mask_wdata` on an edge with `mask_we`=1.
- R9: External event inputs set status bits one edge later. `ext_evt[0]` sets bit 0 (last code). `ext_evt[1]` sets bit 1 (statistics ready). `ext_evt[2]` sets bit 5 (video format error). `ext_evt[3]` sets bit 6 (memory error). Status bit 3 is set one edge after `svc_req` is 1.
- R10: While `rst_n` is 0 the buffer is emptied and `status` and `mask` are cleared, which leaves `irq` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_mode | input | 1 | 0 = encode (coder writes), 1 = decode (host writes) |
| svc_level | input | 4 | Service level; threshold = level*32 |
| host_push | input | 1 | Host write request |
| host_wdata | input | 32 | Host write word |
| host_pop | input | 1 | Host read request |
| host_rdata | output | 32 | Oldest stored word, host side |
| core_push | input | 1 | Coder write request |
| core_wdata | input | 32 | Coder write word |
| core_pop | input | 1 | Coder read request |
| core_rdata | output | 32 | Oldest stored word, coder side |
| ext_evt | input | 4 | External events: last code, stats ready, video error, memory error |
| mask_we | input | 1 | Load the interrupt mask |
| mask_wdata | input | 7 | New mask value |
| stat_clr_we | input | 1 | Apply a write-1-to-clear to the status bits |
| stat_clr_data | input | 7 | Status bits to clear |
| status | output | 7 | Sticky status bits |
| mask | output | 7 | Current interrupt mask |
| irq | output | 1 | Host interrupt |
| svc_req | output | 1 | Live service request |
| fill | output | 10 | Number of stored words |
| full | output | 1 | Buffer holds 512 words |
| empty | output | 1 | Buffer holds no words |

## Verification
The bench tests the threshold at both sides of each boundary and in both directions. This includes level 0, where encode mode always requests service and decode mode requests it only when the buffer is empty. A design with the comparison turned around, or with an off-by-one error, would raise the request one word early or one word late. The bench pushes into a full buffer and pops from an empty one. A wrong design would either corrupt the stored count or fail to record the error. The bench also drives the inactive side's strobes, which a design with a wrong direction multiplexer would accept. Finally it checks that clearing a status bit leaves the other bits alone and that a bit survives after its cause has gone, which a design that drives status directly from live levels would fail.

// File: rtl/hfifo_pkg.sv
package hfifo_pkg;

  localparam int NSTAT = 7;

  // status bit positions
  localparam int ST_LAST  = 0;
  localparam int ST_STATS = 1;
  localparam int ST_STOP  = 2;
  localparam int ST_SVC   = 3;
  localparam int ST_FERR  = 4;
  localparam int ST_VIDEO = 5;
  localparam int ST_MEM   = 6;

  // threshold in entries from the programmed level
  function automatic int unsigned svc_threshold(input logic [3:0] lvl,
                                                input int unsigned scale);
    return int'(lvl) * scale;
  endfunction

  // encode asks to drain at or above, decode asks to refill at or below
  function automatic logic svc_hit(input logic dec, input int unsigned level_fill,
                                   input int unsigned thr);
    return dec ? (level_fill <= thr) : (level_fill >= thr);
  endfunction

  // circular pointer advance for any depth
  function automatic int unsigned ptr_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/hfifo_store.sv
module hfifo_store #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ok,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_ok,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  import hfifo_pkg::*;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wptr <= AW'(ptr_next(32'(wptr), DEPTH));
      if (rd_ok) rptr <= AW'(ptr_next(32'(rptr), DEPTH));
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

endmodule

// File: rtl/hfifo_svc.sv
module hfifo_svc #(
  parameter int DEPTH     = 512,
  parameter int LVL_W     = 4,
  parameter int SVC_SCALE = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             dec_mode,
  input  logic [LVL_W-1:0] level,
  input  logic [CW-1:0]    count,
  input  logic             full,
  input  logic             empty,
  output logic             svc_req,
  output logic             stop_evt
);
  import hfifo_pkg::*;

  int unsigned thr;

  always_comb begin
    thr      = svc_threshold(4'(level), SVC_SCALE);
    svc_req  = svc_hit(dec_mode, 32'(count), thr);
    stop_evt = dec_mode ? empty : full;
  end

endmodule

// File: rtl/hfifo_status.sv
module hfifo_status #(
  parameter int NBITS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] set_vec,
  input  logic             clr_we,
  input  logic [NBITS-1:0] clr_data,
  input  logic             mask_we,
  input  logic [NBITS-1:0] mask_wdata,
  output logic [NBITS-1:0] status,
  output logic [NBITS-1:0] mask,
  output logic             irq
);

  logic [NBITS-1:0] clr_eff;
  logic [NBITS-1:0] pend;

  assign clr_eff = clr_we ? clr_data : '0;

  // one sticky cell per bit; a cause present at the clear edge wins
  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)          status[i] <= 1'b0;
      else if (set_vec[i]) status[i] <= 1'b1;
      else if (clr_eff[i]) status[i] <= 1'b0;
    end
    assign pend[i] = status[i] & mask[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask <= '0;
    else if (mask_we) mask <= mask_wdata;
  end

  assign irq = |pend;

endmodule

// File: rtl/hfifo_host.sv
module hfifo_host #(
  parameter int WIDTH     = 32,
  parameter int DEPTH     = 512,
  parameter int LVL_W     = 4,
  parameter int SVC_SCALE = 32,
  parameter int NEXT      = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NS = hfifo_pkg::NSTAT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_mode,
  input  logic [LVL_W-1:0] svc_level,
  input  logic             host_push,
  input  logic [WIDTH-1:0] host_wdata,
  input  logic             host_pop,
  output logic [WIDTH-1:0] host_rdata,
  input  logic             core_push,
  input  logic [WIDTH-1:0] core_wdata,
  input  logic             core_pop,
  output logic [WIDTH-1:0] core_rdata,
  input  logic [NEXT-1:0]  ext_evt,
  input  logic             mask_we,
  input  logic [NS-1:0]    mask_wdata,
  input  logic             stat_clr_we,
  input  logic [NS-1:0]    stat_clr_data,
  output logic [NS-1:0]    status,
  output logic [NS-1:0]    mask,
  output logic             irq,
  output logic             svc_req,
  output logic [CW-1:0]    fill,
  output logic             full,
  output logic             empty
);
  import hfifo_pkg::*;

  // named internal events, also observed by the checker
  logic             wr_req, rd_req, wr_ok, rd_ok, err_evt, stop_evt;
  logic [WIDTH-1:0] wr_data, head;
  logic [NS-1:0]    set_vec;

  always_comb begin
    wr_req  = dec_mode ? host_push  : core_push;
    wr_data = dec_mode ? host_wdata : core_wdata;
    rd_req  = dec_mode ? core_pop   : host_pop;
    wr_ok   = wr_req & ~full;
    rd_ok   = rd_req & ~empty;
    err_evt = (wr_req & full) | (rd_req & empty);
  end

  hfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_data(wr_data), .rd_ok(rd_ok),
    .head(head), .count(fill), .full(full), .empty(empty)
  );

  hfifo_svc #(.DEPTH(DEPTH), .LVL_W(LVL_W), .SVC_SCALE(SVC_SCALE)) u_svc (
    .dec_mode(dec_mode), .level(svc_level), .count(fill), .full(full), .empty(empty),
    .svc_req(svc_req), .stop_evt(stop_evt)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[ST_LAST]  = ext_evt[0];
    set_vec[ST_STATS] = ext_evt[1];
    set_vec[ST_STOP]  = stop_evt;
    set_vec[ST_SVC]   = svc_req;
    set_vec[ST_FERR]  = err_evt;
    set_vec[ST_VIDEO] = ext_evt[2];
    set_vec[ST_MEM]   = ext_evt[3];
  end

  hfifo_status #(.NBITS(NS)) u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_we(stat_clr_we),
    .clr_data(stat_clr_data), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .status(status), .mask(mask), .irq(irq)
  );

  assign host_rdata = head;
  assign core_rdata = head;

endmodule

// File: rtl/hfifo_host_chk.sv
module hfifo_host_chk #(
  parameter int DEPTH = 512,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NS = hfifo_pkg::NSTAT
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dec_mode,
  input logic          wr_req,
  input logic          rd_req,
  input logic          host_push,
  input logic          host_pop,
  input logic          core_push,
  input logic          core_pop,
  input logic          full,
  input logic          empty,
  input logic          svc_req,
  input logic          irq,
  input logic          stat_clr_we,
  input logic [NS-1:0] stat_clr_data,
  input logic [NS-1:0] status,
  input logic [NS-1:0] mask,
  input logic [CW-1:0] fill
);

  assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, fill} <= (CW+1)'(DEPTH));

  assert_fill_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, fill} == {1'b0, $past(fill)}) ||
             ({1'b0, fill} == {1'b0, $past(fill)} + 1'b1) ||
             ({1'b0, fill} + 1'b1 == {1'b0, $past(fill)}));

  assert_enc_ignores_host_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_mode && !core_push && !host_pop) |=> (fill == $past(fill)));

  assert_dec_ignores_core_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_mode && !host_push && !core_pop) |=> (fill == $past(fill)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && full) |=> status[4]);

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty) |=> (status[4] && ({1'b0, fill} <= 1)));

  assert_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((dec_mode && empty) || (!dec_mode && full)) |=> status[2]);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status) & ~($past(stat_clr_we) ? $past(stat_clr_data) : '0)) & ~status) == '0));

  assert_svc_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |=> status[3]);

  assert_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((status & mask) != '0));

endmodule

bind hfifo_host hfifo_host_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_mode(dec_mode), .wr_req(wr_req), .rd_req(rd_req),
  .host_push(host_push), .host_pop(host_pop), .core_push(core_push), .core_pop(core_pop),
  .full(full), .empty(empty), .svc_req(svc_req), .irq(irq), .stat_clr_we(stat_clr_we),
  .stat_clr_data(stat_clr_data), .status(status), .mask(mask), .fill(fill)
);

// File: tb/hfifo_host_bench.sv
module hfifo_host_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  // {dec, level, words to load, expected svc_req}
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 4'd2,  10'd63,  1'b0},
    {1'b0, 4'd2,  10'd64,  1'b1},
    {1'b0, 4'd0,  10'd0,   1'b1},
    {1'b0, 4'd15, 10'd479, 1'b0},
    {1'b0, 4'd15, 10'd480, 1'b1},
    {1'b1, 4'd4,  10'd128, 1'b1},
    {1'b1, 4'd4,  10'd129, 1'b0},
    {1'b1, 4'd0,  10'd1,   1'b0},
    {1'b1, 4'd0,  10'd0,   1'b1}
  };

  logic clk = 0, rst_n = 0, dec_mode = 0;
  logic [3:0] svc_level = 0;
  logic host_push = 0, host_pop = 0, core_push = 0, core_pop = 0;
  logic [31:0] host_wdata = 0, core_wdata = 0, host_rdata, core_rdata;
  logic [3:0] ext_evt = 0;
  logic mask_we = 0, stat_clr_we = 0;
  logic [6:0] mask_wdata = 0, stat_clr_data = 0, status, mask;
  logic irq, svc_req, full, empty;
  logic [9:0] fill;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hfifo_host u_hfifo_host (
    .clk(clk), .rst_n(rst_n), .dec_mode(dec_mode), .svc_level(svc_level),
    .host_push(host_push), .host_wdata(host_wdata), .host_pop(host_pop), .host_rdata(host_rdata),
    .core_push(core_push), .core_wdata(core_wdata), .core_pop(core_pop), .core_rdata(core_rdata),
    .ext_evt(ext_evt), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .stat_clr_we(stat_clr_we), .stat_clr_data(stat_clr_data), .status(status), .mask(mask),
    .irq(irq), .svc_req(svc_req), .fill(fill), .full(full), .empty(empty)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic dec, input logic [3:0] lvl);
    rst_n = 0; dec_mode = dec; svc_level = lvl;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic push(input logic from_host, input logic [31:0] d);
    if (from_host) begin host_push = 1; host_wdata = d; end
    else begin core_push = 1; core_wdata = d; end
    @(negedge clk);
    host_push = 0; core_push = 0;
  endtask

  task automatic pop(input logic from_host);
    if (from_host) host_pop = 1; else core_pop = 1;
    @(negedge clk);
    host_pop = 0; core_pop = 0;
  endtask

  task automatic clear_status(input logic [6:0] bits);
    stat_clr_we = 1; stat_clr_data = bits;
    @(negedge clk);
    stat_clr_we = 0; stat_clr_data = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R10: reset state
    do_reset(1'b0, 4'd3);
    check("R10 fill", fill, 0);
    check("R10 status", status, 0);
    check("R10 mask", mask, 0);
    check("R10 irq", irq, 0);
    check("R1 empty flag", empty, 1);

    // R4/R5: threshold table
    for (int i = 0; i < NV; i++) begin
      do_reset(VEC[i][15], VEC[i][14:11]);
      for (int n = 0; n < int'(VEC[i][10:1]); n++) push(VEC[i][15], 32'(n));
      check(VEC[i][15] ? "R5 svc_req decode" : "R4 svc_req encode", svc_req, VEC[i][0]);
      check("R1 fill count", fill, VEC[i][10:1]);
    end

    // R1: order, encode direction
    do_reset(1'b0, 4'd1);
    for (int n = 0; n < 5; n++) push(1'b0, 32'hA000_0000 + 32'(n));
    for (int n = 0; n < 5; n++) begin
      check("R1 host_rdata order", host_rdata, 32'hA000_0000 + 32'(n));
      check("R1 core_rdata mirror", core_rdata, 32'hA000_0000 + 32'(n));
      pop(1'b1);
    end
    check("R1 drained", fill, 0);

    // R2: inactive side ignored
    push(1'b1, 32'h1111);
    check("R2 encode host push ignored", fill, 0);
    push(1'b0, 32'h2222);
    pop(1'b0);
    check("R2 encode core pop ignored", fill, 1);
    do_reset(1'b1, 4'd1);
    push(1'b0, 32'h3333);
    check("R2 decode core push ignored", fill, 0);
    push(1'b1, 32'h4444);
    check("R2 decode host push", fill, 1);
    pop(1'b1);
    check("R2 decode host pop ignored", fill, 1);
    check("R1 decode core_rdata", core_rdata, 32'h4444);
    pop(1'b0);
    check("R2 decode core pop", fill, 0);

    // R3: underflow in encode
    do_reset(1'b0, 4'd15);
    pop(1'b1);
    check("R3 underflow fill", fill, 0);
    check("R3 underflow error bit", status[4], 1);
    clear_status(7'h10);
    check("R7 w1c clears error", status[4], 0);

    // R3/R6: overflow in encode
    for (int n = 0; n < 512; n++) push(1'b0, 32'(n));
    check("R1 full flag", full, 1);
    check("R3 no error before overflow", status[4], 0);
    push(1'b0, 32'hDEAD);
    check("R3 overflow fill", fill, 512);
    check("R3 overflow error bit", status[4], 1);
    check("R6 stop set when full in encode", status[2], 1);
    check("R1 head after overflow", host_rdata, 0);

    // R6 decode: stop set one edge after empty
    do_reset(1'b1, 4'd1);
    check("R10 status clear after reset", status, 0);
    @(negedge clk);
    check("R6 stop set when empty in decode", status[2], 1);
    check("R9 svc status follows svc_req", status[3], 1);

    // R7/R8/R9: sticky events and interrupt mask
    do_reset(1'b0, 4'd15);
    ext_evt = 4'b0001; @(negedge clk); ext_evt = 0;
    @(negedge clk);
    check("R9 last code bit0", status, 7'h01);
    check("R8 masked off", irq, 0);
    mask_we = 1; mask_wdata = 7'h01; @(negedge clk); mask_we = 0;
    check("R8 irq with mask", irq, 1);
    clear_status(7'h7E);
    check("R7 clear of other bits keeps bit0", status[0], 1);
    clear_status(7'h01);
    check("R7 w1c bit0", status[0], 0);
    check("R8 irq drops", irq, 0);
    ext_evt = 4'b1110; @(negedge clk); ext_evt = 0;
    check("R9 ext bits 1,5,6", status, 7'h62);
    check("R8 irq masked out", irq, 0);
    mask_we = 1; mask_wdata = 7'h40; @(negedge clk); mask_we = 0;
    check("R8 irq via mem err", irq, 1);
    ext_evt = 4'b1000; stat_clr_we = 1; stat_clr_data = 7'h40;
    @(negedge clk);
    ext_evt = 0; stat_clr_we = 0; stat_clr_data = 0;
    check("R7 set wins over clear", status[6], 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule